// File: doc/BRIEF.md
# Handshake Bus I/O Target

This block is a target on a simple asynchronous request/acknowledge bus with an 8-bit address and an 8-bit data path. The initiator drives a command line, an address, write data and an active-low request. The target answers with an active-low acknowledge. The target exposes two locations. One is a read-only location that reports the state of a push-button. The other is a write-only location that holds a single-bit register driving an LED.

The initiator's lines carry no clock. The target brings every incoming line, and the button, into its own clock domain through multi-stage synchronizers. It acts on a request only after the synchronized command, address and data have stayed unchanged for a set number of local cycles. The transfer is fully interlocked:
- On a read, the target first drives data under an output enable. It then pulls the acknowledge low.
- On a write, it captures the data bit and pulls the acknowledge low.
- In both cases the acknowledge stays low until the request is seen high again. The target then releases the data and raises the acknowledge.

Accesses the target does not decode receive no acknowledge at all.

Top module: `hsbus_target`

## Requirements
- R1: After reset, `ackN` is 1, `dataOe` is 0, `ledOut` is 0 and `dataOut` is 0.
- R2: A read (`cmd`=0) of address 0x04 returns the button state in `dataOut` bit 0 while the acknowledge is low: 1 when `buttonIn` is 1 (pressed), 0 otherwise. Bits 7 to 1 are 0.
- R3: On a read with stable lines and default parameters, `dataOe` rises on the 3rd rising edge after `reqN` falls. `ackN` falls on the 4th edge, so data is driven one cycle before the acknowledge.
- R4: A write (`cmd`=1) to address 0x05 stores `dataIn` bit 0 into `ledOut` on the same edge that `ackN` falls, which is the 3rd rising edge after `reqN` falls. `ledOut` holds its value at all other times.
- R5: `dataOe` stays 0 throughout a write transfer.
- R6: After `reqN` rises, `ackN` returns to 1 on the 3rd rising edge. On a read, `dataOe` returns to 0 on that same edge.
- R7: An access that does not match gets no acknowledge and no data enable, and `ledOut` is unchanged. This covers any address other than 0x04 and 0x05, a write to 0x04, and a read of 0x05. Once `reqN` rises, the target serves the next transfer normally.
- R8: The target starts a transfer only after the synchronized `cmd`, `ads` and `dataIn` have been unchanged for `SETTLE_CYCLES` local cycles. If these lines change together with the falling edge of `reqN`, a write is acknowledged on the 5th rising edge instead of the 3rd.
- R9: Once low, `ackN` stays low for as long as `reqN` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock of the target |
| rstN | input | 1 | Active-low asynchronous reset |
| reqN | input | 1 | Active-low request from the initiator (asynchronous) |
| cmd | input | 1 | Command: 0 read, 1 write (asynchronous) |
| ads | input | 8 | Address from the initiator (asynchronous) |
| dataIn | input | 8 | Write data from the initiator (asynchronous) |
| dataOut | output | 8 | Read data toward the bus pad |
| dataOe | output | 1 | Output enable for the read-data pad driver |
| ackN | output | 1 | Active-low acknowledge to the initiator |
| buttonIn | input | 1 | Push-button level, 1 when pressed (asynchronous) |
| ledOut | output | 1 | LED register output |

## Verification
The bench builds the target with its defaults: two synchronizer stages, one settle cycle, the button at 0x04 and the LED at 0x05. With these values every latency is a small fixed number of edges, so the bench checks exact cycles. A read raises the enable on edge 3 and acknowledges on edge 4. A write acknowledges on edge 3, and the release completes on edge 3. One case moves the address and the request together to expose the settle delay, which pushes the acknowledge to edge 5. Mismatched command and address pairs exercise the no-response path, each followed by a normal transfer.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadRead;   // capture button into read register
    logic clearRead;  // release read register at end of read
    logic writeLed;   // capture write data bit into LED flop
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DRIVE,
    ST_RD_ACK,
    ST_WR_ACK,
    ST_IGNORE
  } ctrlState_t;

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= RESET_VAL;
    else       pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= RESET_VAL;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/hsbus_dp.sv
module hsbus_dp
  import hsbus_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter logic [ADDR_W-1:0] BTN_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] LED_ADDR = 8'h05,
  parameter int SETTLE_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cmdS,
  input  logic [ADDR_W-1:0] adsS,
  input  logic [DATA_W-1:0] dataS,
  input  logic              btnS,
  output logic              busStable,
  output logic              hitRead,
  output logic              hitWrite,
  output logic [DATA_W-1:0] rdData,
  output logic              ledQ
);

  localparam int BUS_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [CNT_W-1:0] SETTLE_MAX = CNT_W'(SETTLE_CYCLES);

  logic [BUS_W-1:0] busNow, busPrev;
  logic [CNT_W-1:0] settleCnt;
  logic             busSame;

  assign busNow  = {cmdS, adsS, dataS};
  assign busSame = (busNow == busPrev);

  // Count consecutive cycles with unchanged synchronized lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPrev   <= '0;
      settleCnt <= '0;
    end else begin
      busPrev <= busNow;
      if (!busSame)                settleCnt <= '0;
      else if (settleCnt < SETTLE_MAX) settleCnt <= settleCnt + 1'b1;
    end
  end

  assign busStable = busSame && (settleCnt >= SETTLE_MAX);

  // Address and command decode
  assign hitRead  = !cmdS && (adsS == BTN_ADDR);
  assign hitWrite =  cmdS && (adsS == LED_ADDR);

  // Read-data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobe.loadRead)  rdData <= DATA_W'(btnS);
    else if (strobe.clearRead) rdData <= '0;
  end

  // LED register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ledQ <= 1'b0;
    else if (strobe.writeLed) ledQ <= dataS[0];
  end

endmodule

// File: rtl/hsbus_ctrl.sv
module hsbus_ctrl
  import hsbus_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqS,
  input  logic      busStable,
  input  logic      hitRead,
  input  logic      hitWrite,
  output dpStrobe_t strobe,
  output logic      ackN,
  output logic      dataOe
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!reqS && busStable) begin
          if (hitRead) begin
            stateNext       = ST_RD_DRIVE;
            strobe.loadRead = 1'b1;
          end else if (hitWrite) begin
            stateNext       = ST_WR_ACK;
            strobe.writeLed = 1'b1;
          end else begin
            stateNext = ST_IGNORE;
          end
        end
      end
      ST_RD_DRIVE: stateNext = ST_RD_ACK;
      ST_RD_ACK: begin
        if (reqS) begin
          stateNext        = ST_IDLE;
          strobe.clearRead = 1'b1;
        end
      end
      ST_WR_ACK: if (reqS) stateNext = ST_IDLE;
      ST_IGNORE: if (reqS) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  // Outputs decoded from the state register only
  assign ackN   = !((state == ST_RD_ACK) || (state == ST_WR_ACK));
  assign dataOe = (state == ST_RD_DRIVE) || (state == ST_RD_ACK);

endmodule

// File: rtl/hsbus_target.sv
module hsbus_target
  import hsbus_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 1,
  parameter logic [ADDR_W-1:0] BTN_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] LED_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqN,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] ads,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ackN,
  input  logic              buttonIn,
  output logic              ledOut
);

  localparam int BUS_W = 1 + ADDR_W + DATA_W;

  logic [BUS_W-1:0]  busSync;
  logic              reqNSync, reqSync, btnSync;
  logic              busStable, hitRead, hitWrite;
  dpStrobe_t         strobe;

  hsbus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_busSync (
    .clk(clk), .rstN(rstN), .din({cmd, ads, dataIn}), .dout(busSync)
  );

  hsbus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_reqSync (
    .clk(clk), .rstN(rstN), .din(reqN), .dout(reqNSync)
  );

  hsbus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_btnSync (
    .clk(clk), .rstN(rstN), .din(buttonIn), .dout(btnSync)
  );

  assign reqSync = !reqNSync;  // 1 while a request is seen

  hsbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqS(reqNSync),
    .busStable(busStable), .hitRead(hitRead), .hitWrite(hitWrite),
    .strobe(strobe), .ackN(ackN), .dataOe(dataOe)
  );

  hsbus_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BTN_ADDR(BTN_ADDR), .LED_ADDR(LED_ADDR),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdS(busSync[BUS_W-1]),
    .adsS(busSync[DATA_W +: ADDR_W]),
    .dataS(busSync[DATA_W-1:0]),
    .btnS(btnSync),
    .busStable(busStable), .hitRead(hitRead), .hitWrite(hitWrite),
    .rdData(dataOut), .ledQ(ledOut)
  );

endmodule

// File: rtl/hsbus_target_chk.sv
module hsbus_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqSync,
  input logic              ackN,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input logic              ledOut
);

  // R2: while driving, only bit 0 may be set
  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> ((dataOut >> 1) == '0));

  // R3: enable rises while acknowledge is still high
  a_r3_oe_before_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> ackN);

  // R3: acknowledge of a read falls only after data was already driven
  a_r3_data_leads_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && dataOe) |-> $past(dataOe));

  // R4: LED changes only on the edge a write is acknowledged
  a_r4_led_on_write_ack: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ledOut) |-> ($fell(ackN) && !dataOe));

  // R6: enable is released together with the acknowledge
  a_r6_oe_release_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOe) |-> $rose(ackN));

  // R6: acknowledge rises only after the request was seen released
  a_r6_ack_rise_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackN) |-> !$past(reqSync));

  // R9: acknowledge falls only while the request is seen
  a_r9_ack_fall_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(reqSync));

endmodule

bind hsbus_target hsbus_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqSync(reqSync), .ackN(ackN),
  .dataOe(dataOe), .dataOut(dataOut), .ledOut(ledOut)
);

// File: tb/hsbus_target_tb.sv
`timescale 1ns/1ps
module hsbus_target_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqN = 1'b1;
  logic       cmd = 1'b0;
  logic [7:0] ads = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       ackN;
  logic       buttonIn = 1'b0;
  logic       ledOut;

  always #2.5 clk = ~clk;

  hsbus_target u_dut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .cmd(cmd), .ads(ads),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .ackN(ackN),
    .buttonIn(buttonIn), .ledOut(ledOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Results of the last watched transfer
  int   ackAt, oeAt, relAck, relOe;
  bit   oeEver, ackReleasedEarly;
  logic [7:0] dataAtAck;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startReq(input logic c, input logic [7:0] a, input logic [7:0] d,
                          input bit together);
    if (!together) begin
      @(negedge clk);
      cmd = c; ads = a; dataIn = d;
      repeat (3) @(negedge clk);
      reqN = 1'b0;
    end else begin
      @(negedge clk);
      cmd = c; ads = a; dataIn = d; reqN = 1'b0;
    end
  endtask

  task automatic watchAck(input int maxCyc);
    ackAt = -1; oeAt = -1; oeEver = 0; ackReleasedEarly = 0; dataAtAck = '0;
    for (int k = 1; k <= maxCyc; k++) begin
      @(negedge clk);
      if (dataOe && oeAt < 0) oeAt = k;
      if (dataOe) oeEver = 1;
      if (!ackN && ackAt < 0) begin
        ackAt = k;
        dataAtAck = dataOut;
      end
      if (ackN && ackAt >= 0) ackReleasedEarly = 1;
    end
  endtask

  task automatic finishReq();
    relAck = -1; relOe = -1;
    reqN = 1'b1;  // called right after a negedge sample
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (dataOe) oeEver = 1;
      if (ackN && relAck < 0) relAck = k;
      if (!dataOe && relOe < 0) relOe = k;
    end
    cmd = 1'b0; ads = '0; dataIn = '0;
  endtask

  task automatic testReset();
    chk("R1 ackN", ackN, 1);
    chk("R1 dataOe", dataOe, 0);
    chk("R1 ledOut", ledOut, 0);
    chk("R1 dataOut", dataOut, 0);
  endtask

  task automatic testReadButton(input logic btn);
    buttonIn = btn;
    repeat (4) @(negedge clk);
    startReq(1'b0, 8'h04, 8'hA5, 0);
    watchAck(8);
    chk("R3 read ack edge", ackAt, 4);
    chk("R3 read oe edge", oeAt, 3);
    chk("R2 read data", dataAtAck, {7'b0, btn});
    finishReq();
    chk("R6 read ack release", relAck, 3);
    chk("R6 read oe release", relOe, 3);
  endtask

  task automatic testWriteLed(input logic [7:0] d);
    startReq(1'b1, 8'h05, d, 0);
    watchAck(8);
    chk("R4 write ack edge", ackAt, 3);
    chk("R4 led value", ledOut, d[0]);
    chk("R5 no oe in write", oeEver, 0);
    finishReq();
    chk("R6 write ack release", relAck, 3);
    chk("R5 no oe in write release", oeEver, 0);
    chk("R4 led holds", ledOut, d[0]);
  endtask

  task automatic testHold();
    startReq(1'b1, 8'h05, 8'h00, 0);
    watchAck(15);
    chk("R9 ack fell", ackAt, 3);
    chk("R9 ack held low", ackReleasedEarly, 0);
    finishReq();
    chk("R9 ack released after req", relAck, 3);
  endtask

  task automatic testIgnore(input logic c, input logic [7:0] a, input logic [7:0] d);
    logic ledBefore;
    ledBefore = ledOut;
    startReq(c, a, d, 0);
    watchAck(15);
    chk("R7 no ack", ackAt, -1);
    chk("R7 no oe", oeEver, 0);
    chk("R7 led unchanged", ledOut, ledBefore);
    finishReq();
    chk("R7 ack stays high", ackN, 1);
  endtask

  task automatic testSettle();
    startReq(1'b1, 8'h05, 8'h01, 1);
    watchAck(10);
    chk("R8 settle delays ack", ackAt, 5);
    chk("R8 led written", ledOut, 1);
    finishReq();
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadButton(1'b1);
    testReadButton(1'b0);
    testWriteLed(8'hF5);
    testWriteLed(8'hF4);
    testWriteLed(8'h01);
    testIgnore(1'b1, 8'h04, 8'hFE);  // write to the button location
    testWriteLed(8'hFE);
    testIgnore(1'b1, 8'h04, 8'hFF);
    testIgnore(1'b0, 8'h05, 8'h00);  // read of the LED location
    testIgnore(1'b0, 8'h07, 8'h00);
    testIgnore(1'b1, 8'h06, 8'h01);
    testReadButton(1'b1);            // served normally after ignores
    testHold();
    testSettle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule